// File: doc/BRIEF.md
# 1-Wire Search ROM Accelerator

This block speeds up the search for the 64-bit identifiers of devices sharing a 1-Wire bus. It sits between the host's data register and a bit-level slot engine that performs single read and write time slots on the wire. The host first issues the bus reset and the search command byte through the ordinary paths. It then raises search mode and exchanges one byte per group of identifier bits. A whole identifier takes 16 exchanges, least significant group first.

Each byte the host writes carries one direction choice per identifier bit, placed on the odd bit positions. For every identifier bit the accelerator runs three slots in order: a read of the true bit, a read of its complement, and a write of the chosen direction. It combines the two reads with the host's choice to pick the direction and to flag a discrepancy. When the last write slot of the group ends, it presents a byte that packs the resolved bits on odd positions and the discrepancy flags on even positions, and raises the same receive-buffer-full status that normal byte reads use. Choosing the next branch and spotting a bus error are left to the host. A bus error shows as both bits set for identifier bit 63.

Top module: `srch_accel`

## Requirements
- R1: While reset is active and after it is released, `rx_full` and `slot_req` are 0 and `rd_byte` is 0.
- R2: A byte written while `search_en` is 0 starts no slot and leaves `rx_full` and `rd_byte` unchanged.
- R3: An exchange runs 3 slots per identifier bit, bits in ascending order: read, read, write. `slot_kind` is 0 for a read and 1 for a write. `slot_req` stays high with `slot_kind` and `slot_wbit` stable until `slot_done` is pulsed.
- R4: The choice for identifier bit k (k = 0 to NIB_BITS-1) is taken from bit 2k+1 of the written byte. The even bits of the written byte have no effect.
- R5: If the first read (true bit) and the second read (complement) differ, the write slot sends the first read value. The resolved bit equals the first read value and the discrepancy flag is 0.
- R6: If both reads return 0, the write slot sends the host's choice. The resolved bit equals that choice and the discrepancy flag is 1.
- R7: If both reads return 1 (no responder), the write slot sends 1. The resolved bit and the discrepancy flag are both 1.
- R8: In the returned byte, bit 2k+1 is the resolved bit k and bit 2k is the discrepancy flag k. `rd_byte` changes only when the final write slot of an exchange completes.
- R9: `rx_full` rises in the cycle after the final write slot's `slot_done`. It is cleared in the cycle after an `rd_ack` pulse.
- R10: A byte written while an exchange is in progress is ignored.
- R11: Clearing `search_en` aborts an exchange: `slot_req` is low from the next cycle, the partial result is dropped, and `rx_full` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Search mode enable (command bit 1) |
| wr_valid | input | 1 | One-cycle pulse: host writes the data register |
| wr_byte | input | 2*NIB_BITS | Written byte, choice bits on odd positions |
| rd_ack | input | 1 | One-cycle pulse: host has read the result |
| rd_byte | output | 2*NIB_BITS | Packed resolved bits and discrepancy flags |
| rx_full | output | 1 | Receive buffer full status |
| slot_req | output | 1 | Request a slot from the slot engine |
| slot_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot (1 during reads) |
| slot_done | input | 1 | One-cycle pulse: requested slot finished |
| slot_rbit | input | 1 | Sampled bus value, valid with `slot_done` |

## Verification
The bench builds the block with NIB_BITS = 4, the byte width used on the wire. With that width, all 256 combinations of read-slot answers across the four identifier bits can be swept. Each combination is crossed with several choice nibbles, with and without noise on the even bits, so every mix of the three resolution cases appears at every bit position. A second sweep runs all 16 choice nibbles against an all-conflict bus. Directed cases cover writes outside search mode, writes during an exchange, and an abort part-way through an exchange.

// File: rtl/srch_accel_pkg.sv
package srch_accel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_TRUE = 2'd1,
    ST_RD_CPL  = 2'd2,
    ST_WR      = 2'd3
  } srch_state_e;

  localparam logic SLOT_READ  = 1'b0;
  localparam logic SLOT_WRITE = 1'b1;
endpackage

// File: rtl/srch_bit_resolve.sv
// Decides the direction for one identifier bit from its two read slots.
module srch_bit_resolve (
  input  logic rd_true,
  input  logic rd_cpl,
  input  logic choice,
  output logic id_bit,
  output logic disc,
  output logic wr_bit
);
  always_comb begin
    if (rd_true != rd_cpl) begin
      id_bit = rd_true;
      disc   = 1'b0;
    end else if (!rd_true) begin
      id_bit = choice;
      disc   = 1'b1;
    end else begin
      id_bit = 1'b1;
      disc   = 1'b1;
    end
    wr_bit = id_bit;
  end
endmodule

// File: rtl/srch_seq.sv
// Slot sequencer: read, complement read, write for each bit of a group.
module srch_seq
  import srch_accel_pkg::*;
#(
  parameter int NIB_BITS = 4,
  localparam int IDX_W = (NIB_BITS > 1) ? $clog2(NIB_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_en,
  input  logic             wr_valid,
  input  logic             slot_done,
  output srch_state_e      state,
  output logic [IDX_W-1:0] bit_idx,
  output logic             start,
  output logic             cap_true,
  output logic             cap_cpl,
  output logic             bit_done,
  output logic             last_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIB_BITS - 1);

  srch_state_e      state_nx;
  logic [IDX_W-1:0] idx_nx;
  logic             idx_en;

  always_comb begin
    start     = search_en && wr_valid && (state == ST_IDLE);
    cap_true  = search_en && slot_done && (state == ST_RD_TRUE);
    cap_cpl   = search_en && slot_done && (state == ST_RD_CPL);
    bit_done  = search_en && slot_done && (state == ST_WR);
    last_done = bit_done && (bit_idx == LAST_IDX);
  end

  always_comb begin
    state_nx = state;
    idx_nx   = bit_idx;
    idx_en   = 1'b0;
    if (!search_en) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state_nx = ST_RD_TRUE;
          idx_nx   = '0;
          idx_en   = 1'b1;
        end
        ST_RD_TRUE: if (cap_true) state_nx = ST_RD_CPL;
        ST_RD_CPL:  if (cap_cpl)  state_nx = ST_WR;
        ST_WR: if (bit_done) begin
          if (last_done) begin
            state_nx = ST_IDLE;
          end else begin
            state_nx = ST_RD_TRUE;
            idx_nx   = bit_idx + 1'b1;
            idx_en   = 1'b1;
          end
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
    end else begin
      state <= state_nx;
      if (idx_en) bit_idx <= idx_nx;
    end
  end
endmodule

// File: rtl/srch_pack.sv
// Holds the choices, captures the reads and assembles the returned byte.
module srch_pack #(
  parameter int NIB_BITS = 4,
  localparam int IDX_W  = (NIB_BITS > 1) ? $clog2(NIB_BITS) : 1,
  localparam int BYTE_W = 2 * NIB_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              cap_true,
  input  logic              cap_cpl,
  input  logic              bit_done,
  input  logic              last_done,
  input  logic              slot_rbit,
  input  logic              rd_ack,
  output logic              wr_bit,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rx_full
);
  logic [NIB_BITS-1:0] choice_in;
  logic [NIB_BITS-1:0] choice_q;
  logic                rd_true_q;
  logic                rd_cpl_q;
  logic [BYTE_W-1:0]   work_q;
  logic [BYTE_W-1:0]   work_nx;
  logic                id_bit;
  logic                disc;
  logic                full_nx;

  for (genvar k = 0; k < NIB_BITS; k++) begin : g_choice
    assign choice_in[k] = wr_byte[2*k+1];
  end

  srch_bit_resolve u_resolve (
    .rd_true (rd_true_q),
    .rd_cpl  (rd_cpl_q),
    .choice  (choice_q[bit_idx]),
    .id_bit  (id_bit),
    .disc    (disc),
    .wr_bit  (wr_bit)
  );

  always_comb begin
    work_nx = work_q;
    work_nx[{bit_idx, 1'b1}] = id_bit;
    work_nx[{bit_idx, 1'b0}] = disc;
    full_nx = rx_full;
    if (last_done)   full_nx = 1'b1;
    else if (rd_ack) full_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      choice_q  <= '0;
      rd_true_q <= 1'b0;
      rd_cpl_q  <= 1'b0;
      work_q    <= '0;
      rd_byte   <= '0;
      rx_full   <= 1'b0;
    end else begin
      if (start)     choice_q  <= choice_in;
      if (cap_true)  rd_true_q <= slot_rbit;
      if (cap_cpl)   rd_cpl_q  <= slot_rbit;
      if (start)          work_q <= '0;
      else if (bit_done)  work_q <= work_nx;
      if (last_done) rd_byte <= work_nx;
      rx_full <= full_nx;
    end
  end
endmodule

// File: rtl/srch_accel.sv
module srch_accel
  import srch_accel_pkg::*;
#(
  parameter int NIB_BITS = 4,
  localparam int IDX_W  = (NIB_BITS > 1) ? $clog2(NIB_BITS) : 1,
  localparam int BYTE_W = 2 * NIB_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              search_en,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_ack,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rx_full,
  output logic              slot_req,
  output logic              slot_kind,
  output logic              slot_wbit,
  input  logic              slot_done,
  input  logic              slot_rbit
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  srch_state_e      state;
  logic [IDX_W-1:0] bit_idx;
  logic             start;
  logic             cap_true;
  logic             cap_cpl;
  logic             bit_done;
  logic             last_done;
  logic             wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  srch_seq #(.NIB_BITS(NIB_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .search_en (search_en),
    .wr_valid  (wr_valid),
    .slot_done (slot_done),
    .state     (state),
    .bit_idx   (bit_idx),
    .start     (start),
    .cap_true  (cap_true),
    .cap_cpl   (cap_cpl),
    .bit_done  (bit_done),
    .last_done (last_done)
  );

  srch_pack #(.NIB_BITS(NIB_BITS)) u_pack (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .start     (start),
    .wr_byte   (wr_byte),
    .bit_idx   (bit_idx),
    .cap_true  (cap_true),
    .cap_cpl   (cap_cpl),
    .bit_done  (bit_done),
    .last_done (last_done),
    .slot_rbit (slot_rbit),
    .rd_ack    (rd_ack),
    .wr_bit    (wr_bit),
    .rd_byte   (rd_byte),
    .rx_full   (rx_full)
  );

  always_comb begin
    slot_req  = (state != ST_IDLE);
    slot_kind = (state == ST_WR) ? SLOT_WRITE : SLOT_READ;
    slot_wbit = (state == ST_WR) ? wr_bit : 1'b1;
  end
endmodule

// File: rtl/srch_accel_chk.sv
module srch_accel_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              search_en,
  input logic              rd_ack,
  input logic [BYTE_W-1:0] rd_byte,
  input logic              rx_full,
  input logic              slot_req,
  input logic              slot_kind,
  input logic              slot_wbit,
  input logic              slot_done
);
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> !slot_req); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_done && search_en) |=>
      (slot_req && $stable(slot_kind) && $stable(slot_wbit))); // R3

  AST_FULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(slot_done && slot_kind && search_en)); // R9

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rd_ack)); // R9

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_done) |-> $stable(rd_byte)); // R8

  AST_IDLE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !slot_req); // R8
endmodule

bind srch_accel srch_accel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .search_en (search_en),
  .rd_ack    (rd_ack),
  .rd_byte   (rd_byte),
  .rx_full   (rx_full),
  .slot_req  (slot_req),
  .slot_kind (slot_kind),
  .slot_wbit (slot_wbit),
  .slot_done (slot_done)
);

// File: tb/srch_accel_test.sv
`timescale 1ns/1ps
module srch_accel_test;
  localparam int NIB = 4;
  localparam int BW  = 2 * NIB;

  logic          clk;
  logic          rst_n;
  logic          search_en;
  logic          wr_valid;
  logic [BW-1:0] wr_byte;
  logic          rd_ack;
  logic [BW-1:0] rd_byte;
  logic          rx_full;
  logic          slot_req;
  logic          slot_kind;
  logic          slot_wbit;
  logic          slot_done;
  logic          slot_rbit;

  int checks = 0;
  int fails  = 0;
  logic [NIB-1:0] ra, rb, wr_seen;
  int eng_idx = 0;
  int kind_err = 0;
  logic [BW-1:0] last_exp = '0;

  srch_accel #(.NIB_BITS(NIB)) uut (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .rd_ack(rd_ack), .rd_byte(rd_byte), .rx_full(rx_full),
    .slot_req(slot_req), .slot_kind(slot_kind), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Slot engine model: answers each request one cycle later.
  initial begin
    slot_done = 1'b0;
    slot_rbit = 1'b0;
    forever begin
      @(negedge clk);
      if (slot_done) begin
        slot_done = 1'b0;
      end else if (slot_req) begin
        if (eng_idx >= 3 * NIB) begin
          kind_err++;
        end else begin
          int k;
          int ph;
          k  = eng_idx / 3;
          ph = eng_idx % 3;
          if (slot_kind !== (ph == 2)) kind_err++;
          if (ph == 0)      slot_rbit = ra[k];
          else if (ph == 1) slot_rbit = rb[k];
          else              wr_seen[k] = slot_wbit;
        end
        eng_idx++;
        slot_done = 1'b1;
      end
    end
  end

  function automatic logic [BW-1:0] spread(input logic [NIB-1:0] nib, input logic [BW-1:0] noise);
    logic [BW-1:0] b;
    b = noise & {NIB{2'b01}};
    for (int k = 0; k < NIB; k++) b[2*k+1] = nib[k];
    return b;
  endfunction

  task automatic exchange(input logic [BW-1:0] byt, input logic [NIB-1:0] a,
                          input logic [NIB-1:0] c, input bit busy_wr);
    logic [BW-1:0]  exp_b;
    logic [NIB-1:0] exp_w;
    int waited;
    for (int k = 0; k < NIB; k++) begin
      logic ch;
      ch = byt[2*k+1];
      if (a[k] != c[k])  begin exp_b[2*k+1] = a[k]; exp_b[2*k] = 1'b0; exp_w[k] = a[k]; end // R5
      else if (!a[k])    begin exp_b[2*k+1] = ch;   exp_b[2*k] = 1'b1; exp_w[k] = ch;   end // R6
      else               begin exp_b[2*k+1] = 1'b1; exp_b[2*k] = 1'b1; exp_w[k] = 1'b1; end // R7
    end
    ra = a; rb = c; wr_seen = '0; eng_idx = 0; kind_err = 0;
    @(negedge clk); wr_valid = 1'b1; wr_byte = byt;
    @(negedge clk); wr_valid = 1'b0;
    if (busy_wr) begin
      @(negedge clk); wr_valid = 1'b1; wr_byte = ~byt;
      @(negedge clk); wr_valid = 1'b0;
      check("R8 byte held mid-exchange", rd_byte, last_exp);
    end
    waited = 0;
    while (!rx_full && waited < 200) begin @(negedge clk); waited++; end
    check("R9 rx_full after exchange", rx_full, 1);
    check("R5/R6/R7/R8/R10 returned byte", rd_byte, exp_b);
    check("R4/R5/R6/R7 written-back bits", wr_seen, exp_w);
    check("R3 slot order and count", {kind_err[15:0], eng_idx[15:0]}, {16'd0, 16'(3*NIB)});
    last_exp = exp_b;
    rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    check("R9 rx_full cleared by rd_ack", rx_full, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NIB-1:0] nibs [4];
    nibs[0] = 4'h0; nibs[1] = 4'hF; nibs[2] = 4'h5; nibs[3] = 4'hA;
    rst_n = 1'b0; search_en = 1'b0; wr_valid = 1'b0; wr_byte = '0; rd_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rx_full in reset", rx_full, 0);
    check("R1 slot_req in reset", slot_req, 0);
    check("R1 rd_byte in reset", rd_byte, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rx_full after reset", rx_full, 0);
    check("R1 slot_req after reset", slot_req, 0);

    // R2: write outside search mode
    wr_valid = 1'b1; wr_byte = 8'hFF;
    @(negedge clk); wr_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check("R2 no slot when search off", slot_req, 0);
      @(negedge clk);
    end
    check("R2 rx_full unchanged", rx_full, 0);
    check("R2 rd_byte unchanged", rd_byte, 0);

    search_en = 1'b1;
    @(negedge clk);
    // Full sweep of read answers against several choice nibbles.
    for (int r = 0; r < 256; r++) begin
      for (int n = 0; n < 4; n++) begin
        logic [NIB-1:0] a, c;
        for (int k = 0; k < NIB; k++) begin a[k] = r[2*k]; c[k] = r[2*k+1]; end
        exchange(spread(nibs[n], (n[0]) ? 8'h55 : 8'h00), a, c, 1'b0);
      end
    end
    // All choices against an all-conflict bus, with even-bit noise (R4).
    for (int n = 0; n < 16; n++) exchange(spread(4'(n), 8'(n * 37)), 4'h0, 4'h0, 1'b0);
    // R10: write during an exchange is ignored.
    exchange(spread(4'h6, 8'h00), 4'h0, 4'h0, 1'b1);
    exchange(spread(4'h9, 8'h55), 4'h3, 4'h5, 1'b1);

    // R11: abort part-way.
    ra = 4'h0; rb = 4'hF; eng_idx = 0; kind_err = 0;
    wr_valid = 1'b1; wr_byte = 8'hAA;
    @(negedge clk); wr_valid = 1'b0;
    repeat (5) @(negedge clk);
    search_en = 1'b0;
    @(negedge clk);
    check("R11 slot_req drops after abort", slot_req, 0);
    repeat (30) @(negedge clk);
    check("R11 no rx_full after abort", rx_full, 0);
    check("R11 rd_byte unchanged after abort", rd_byte, last_exp);
    search_en = 1'b1;
    repeat (2) @(negedge clk);
    exchange(spread(4'hC, 8'h00), 4'h1, 4'h2, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule